// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Port

This block gives a host processor a path to all of a card's local memory through a small I/O window alone, with no memory-mapped aperture. The host loads a 15-bit local address pointer through two byte registers. It picks the target device (flash or SRAM) and a two-bit bank with a select register. It then moves data through any one of four data-port aliases. Each data-port access becomes one local memory cycle at the current pointer, and the pointer then steps forward by one. A block transfer is therefore a single pointer load followed by a run of data-port accesses.

The window holds a general configuration byte, the select register, the two pointer bytes and the four data-port aliases. In its wide form it also holds a file of 32 extra byte registers, which this block keeps as plain storage. A control bit in the select register chooses a 16-byte window or a 40-byte window. The port answers nothing while the host-assigned configuration index is zero. Host cycles are single-cycle strobes. Read data comes back on the following cycle, with an output-enable that models the driven data bus.

Top module: `imp_port`

## Requirements
- R1: After reset the general configuration byte, the select register, the pointer and all 32 extra registers are 00h, and `io_rdata_oe` is low.
- R2: While `cfg_index` is zero every host access is ignored: no register changes, no memory strobe, and `io_rdata_oe` stays low on the following cycle.
- R3: Bit 2 of the select register sets the window. When it is 0, offsets 0 to 15 answer. When it is 1, offsets 0 to 39 answer. An access at a higher offset changes nothing and produces no read response.
- R4: Offset 0 (general configuration) and offset 1 (select) are full read/write bytes. Offset 2 holds pointer bits 7:0. Offset 3 holds pointer bits 14:8 in data bits 6:0, and its bit 7 reads as 0.
- R5: A read at offsets 4 to 7 raises `mem_rd` in the same cycle. `mem_addr` is {select bits 4:3, pointer}. Select bit 5 = 1 raises `mem_flash_ce` and 0 raises `mem_sram_ce`. The byte on `mem_rdata` in that cycle is returned to the host.
- R6: A write at offsets 4 to 7 raises `mem_wr` with `mem_wdata` equal to the host byte, at the pre-increment address. `mem_rd` and `mem_wr` are never high together.
- R7: Every data-port access, read or write and through any of the four aliases, adds one to the pointer after the access.
- R8: The pointer wraps from 7FFFh to 0000h, and the bank bits in `mem_addr[16:15]` stay unchanged.
- R9: In the narrow window, offsets 8 to 15 read 00h and ignore writes. In the wide window, offsets 8 to 39 are the 32 extra registers (offset 8 + n is register n), and they store and return bytes.
- R10: The read response (`io_rdata_oe` high with the data) appears exactly on the cycle after a read strobe that is answered, and only then. If `io_rd` and `io_wr` are both high, the access counts as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_index | input | 6 | Host-assigned configuration index; zero disables the port |
| io_addr | input | 6 | Byte offset within the I/O window |
| io_rd | input | 1 | Single-cycle host read strobe |
| io_wr | input | 1 | Single-cycle host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid when io_rdata_oe is high |
| io_rdata_oe | output | 1 | Read data bus drive enable |
| mem_addr | output | 17 | Local memory address {bank, pointer} |
| mem_wdata | output | 8 | Local memory write data |
| mem_rdata | input | 8 | Local memory read data, sampled at the access edge |
| mem_rd | output | 1 | Local memory read strobe |
| mem_wr | output | 1 | Local memory write strobe |
| mem_flash_ce | output | 1 | Flash chip enable |
| mem_sram_ce | output | 1 | SRAM chip enable |

## Verification
The bench builds the block with its default parameters: a 15-bit pointer, a 2-bit bank, a 6-bit offset and 32 extra registers in a 16- or 40-byte window. These defaults let a short run reach the 7FFFh pointer wrap, all four bank codes with both devices, and both window edges (offsets 15/16 and 39/40). They also cover the full extra-register file. The bench's memory is a pure function of device and address. Each returned byte therefore shows which address and device the block actually drove.

// File: rtl/imp_pkg.sv
package imp_pkg;

    // Fixed register offsets inside the window
    localparam int OFS_GCR  = 0;
    localparam int OFS_SEL  = 1;
    localparam int OFS_PLO  = 2;
    localparam int OFS_PHI  = 3;
    localparam int OFS_DP0  = 4;
    localparam int NUM_DP   = 4;

    // Select register field positions
    localparam int SEL_WIDE_BIT = 2;
    localparam int SEL_BANK_LSB = 3;

    typedef enum logic [2:0] {
        CL_NONE = 3'd0,
        CL_GCR  = 3'd1,
        CL_SEL  = 3'd2,
        CL_PLO  = 3'd3,
        CL_PHI  = 3'd4,
        CL_DATA = 3'd5,
        CL_RSVD = 3'd6,
        CL_XREG = 3'd7
    } acc_class_e;

endpackage

// File: rtl/imp_decode.sv
module imp_decode
    import imp_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int CFG_W       = 6,
    parameter int NUM_XREG    = 32,
    parameter int XREG_BASE   = 8,
    parameter int NARROW_SIZE = 16,
    parameter int WIDE_SIZE   = 40,
    localparam int XIDX_W     = $clog2(NUM_XREG)
) (
    input  logic [CFG_W-1:0]  cfg_index,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    output acc_class_e        cls,
    output logic [XIDX_W-1:0] xidx
);

    localparam logic [ADDR_W-1:0] LIM_N  = ADDR_W'(NARROW_SIZE);
    localparam logic [ADDR_W-1:0] LIM_W  = ADDR_W'(WIDE_SIZE);
    localparam logic [ADDR_W-1:0] XBASE  = ADDR_W'(XREG_BASE);
    localparam logic [ADDR_W-1:0] DP_LO  = ADDR_W'(OFS_DP0);
    localparam logic [ADDR_W-1:0] DP_HI  = ADDR_W'(OFS_DP0 + NUM_DP);

    logic [ADDR_W-1:0] limit;
    logic              hit;
    logic [ADDR_W-1:0] xoff;

    always_comb begin
        limit = wide ? LIM_W : LIM_N;
        hit   = (cfg_index != '0) && (addr < limit);
        xoff  = addr - XBASE;
        xidx  = xoff[XIDX_W-1:0];
        cls   = CL_NONE;
        if (hit) begin
            if (addr == ADDR_W'(OFS_GCR))      cls = CL_GCR;
            else if (addr == ADDR_W'(OFS_SEL)) cls = CL_SEL;
            else if (addr == ADDR_W'(OFS_PLO)) cls = CL_PLO;
            else if (addr == ADDR_W'(OFS_PHI)) cls = CL_PHI;
            else if (addr >= DP_LO && addr < DP_HI) cls = CL_DATA;
            else if (wide && addr >= XBASE)    cls = CL_XREG;
            else                               cls = CL_RSVD;
        end
    end

endmodule

// File: rtl/imp_xregs.sv
module imp_xregs #(
    parameter int NUM_XREG = 32,
    localparam int XIDX_W  = $clog2(NUM_XREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [XIDX_W-1:0] idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] store_q [NUM_XREG];

    for (genvar i = 0; i < NUM_XREG; i++) begin : g_cell
        logic [7:0] cell_d;
        always_comb begin
            cell_d = store_q[i];
            if (we && (idx == XIDX_W'(i))) cell_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) store_q[i] <= 8'h00;
            else        store_q[i] <= cell_d;
        end
    end

    assign rdata = store_q[idx];

endmodule

// File: rtl/imp_port.sv
module imp_port
    import imp_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int CFG_W       = 6,
    parameter int PTR_W       = 15,
    parameter int BANK_W      = 2,
    parameter int NUM_XREG    = 32,
    parameter int XREG_BASE   = 8,
    parameter int NARROW_SIZE = 16,
    parameter int WIDE_SIZE   = 40,
    localparam int MEM_AW     = PTR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_index,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rdata_oe,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_flash_ce,
    output logic              mem_sram_ce
);

    localparam int XIDX_W  = $clog2(NUM_XREG);
    localparam int DEV_BIT = SEL_BANK_LSB + BANK_W;

    typedef struct packed {
        logic [7:0]       gcr;
        logic [7:0]       sel;
        logic [PTR_W-1:0] ptr;
        logic [7:0]       rdata;
        logic             oe;
    } state_t;

    state_t st_d, st_q;

    acc_class_e        cls;
    logic [XIDX_W-1:0] xidx;
    logic [7:0]        x_rdata;
    logic              x_we;
    logic              rd_go, wr_go;
    logic [7:0]        rd_val;
    logic [15:0]       ptr_wide;

    imp_decode #(
        .ADDR_W(ADDR_W), .CFG_W(CFG_W), .NUM_XREG(NUM_XREG),
        .XREG_BASE(XREG_BASE), .NARROW_SIZE(NARROW_SIZE), .WIDE_SIZE(WIDE_SIZE)
    ) u_decode (
        .cfg_index(cfg_index),
        .wide     (st_q.sel[SEL_WIDE_BIT]),
        .addr     (io_addr),
        .cls      (cls),
        .xidx     (xidx)
    );

    imp_xregs #(.NUM_XREG(NUM_XREG)) u_xregs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (x_we),
        .idx  (xidx),
        .wdata(io_wdata),
        .rdata(x_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.oe  = 1'b0;
        st_d.rdata = 8'h00;
        wr_go    = io_wr;
        rd_go    = io_rd && !io_wr;
        rd_val   = 8'h00;
        x_we     = 1'b0;
        ptr_wide = 16'(st_q.ptr);
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;

        case (cls)
            CL_GCR: begin
                rd_val = st_q.gcr;
                if (wr_go) st_d.gcr = io_wdata;
            end
            CL_SEL: begin
                rd_val = st_q.sel;
                if (wr_go) st_d.sel = io_wdata;
            end
            CL_PLO: begin
                rd_val = ptr_wide[7:0];
                if (wr_go) st_d.ptr[7:0] = io_wdata;
            end
            CL_PHI: begin
                rd_val = ptr_wide[15:8];
                if (wr_go) st_d.ptr[PTR_W-1:8] = io_wdata[PTR_W-9:0];
            end
            CL_DATA: begin
                rd_val = mem_rdata;
                mem_rd = rd_go;
                mem_wr = wr_go;
                if (rd_go || wr_go) st_d.ptr = st_q.ptr + 1'b1;
            end
            CL_XREG: begin
                rd_val = x_rdata;
                x_we   = wr_go;
            end
            default: rd_val = 8'h00;
        endcase

        if (rd_go && (cls != CL_NONE)) begin
            st_d.oe    = 1'b1;
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr     = {st_q.sel[SEL_BANK_LSB +: BANK_W], st_q.ptr};
    assign mem_wdata    = io_wdata;
    assign mem_flash_ce = (mem_rd || mem_wr) && st_q.sel[DEV_BIT];
    assign mem_sram_ce  = (mem_rd || mem_wr) && !st_q.sel[DEV_BIT];
    assign io_rdata     = st_q.rdata;
    assign io_rdata_oe  = st_q.oe;

endmodule

// File: rtl/imp_port_chk.sv
module imp_port_chk #(
    parameter int CFG_W  = 6,
    parameter int PTR_W  = 15,
    parameter int BANK_W = 2,
    localparam int MEM_AW = PTR_W + BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_W-1:0]  cfg_index,
    input logic              io_rd,
    input logic              io_wr,
    input logic              io_rdata_oe,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_flash_ce,
    input logic              mem_sram_ce,
    input logic [MEM_AW-1:0] mem_addr
);

    AST_OFF_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_index == '0) |-> !(mem_rd || mem_wr)); // R2

    AST_OFF_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_index == '0) |=> !io_rdata_oe); // R2

    AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> ($countones({mem_flash_ce, mem_sram_ce}) == 1)); // R5

    AST_NO_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd || mem_wr) |-> !(mem_flash_ce || mem_sram_ce)); // R5

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R6

    AST_PTR_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=>
        (mem_addr[PTR_W-1:0] == PTR_W'($past(mem_addr[PTR_W-1:0]) + 1'b1))); // R7

    AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> $stable(mem_addr[MEM_AW-1:PTR_W])); // R8

    AST_RESP_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> ($past(io_rd) && !$past(io_wr))); // R10

endmodule

bind imp_port imp_port_chk #(
    .CFG_W(CFG_W), .PTR_W(PTR_W), .BANK_W(BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_index   (cfg_index),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_rdata_oe (io_rdata_oe),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_flash_ce(mem_flash_ce),
    .mem_sram_ce (mem_sram_ce),
    .mem_addr    (mem_addr)
);

// File: tb/test_imp_port.sv
`timescale 1ns/1ps
module test_imp_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_index = '0;
    logic [5:0]  io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, mem_flash_ce, mem_sram_ce;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    int         m_gcr, m_sel, m_ptr;
    logic [7:0] m_x [32];

    always #4 clk = ~clk;

    function automatic logic [7:0] memfn(input logic f, input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'b0} ^ (f ? 8'h5A : 8'h00);
    endfunction

    assign mem_rdata = memfn(mem_flash_ce, mem_addr);

    imp_port i_imp_port (
        .clk(clk), .rst_n(rst_n), .cfg_index(cfg_index),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_flash_ce(mem_flash_ce), .mem_sram_ce(mem_sram_ce)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit rd, input bit wr, input int a, input int wd, input string req);
        bit en, hit, dp, wide, e_mrd, e_mwr, e_oe;
        int lim, rv, maddr;
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_addr = 6'(a); io_wdata = 8'(wd);
        #1;
        en    = (cfg_index != 0);
        wide  = m_sel[2];
        lim   = wide ? 40 : 16;
        hit   = en && (a < lim);
        dp    = (a >= 4) && (a < 8);
        e_mrd = hit && dp && rd && !wr;
        e_mwr = hit && dp && wr;
        maddr = ((m_sel >> 3) & 3) * 32768 + m_ptr;
        chk(req, "mem_rd", int'(mem_rd), int'(e_mrd));
        chk(req, "mem_wr", int'(mem_wr), int'(e_mwr));
        chk(req, "mem_flash_ce", int'(mem_flash_ce), int'((e_mrd || e_mwr) && m_sel[5]));
        chk(req, "mem_sram_ce", int'(mem_sram_ce), int'((e_mrd || e_mwr) && !m_sel[5]));
        chk(req, "mem_addr", int'(mem_addr), maddr);
        if (e_mwr) chk(req, "mem_wdata", int'(mem_wdata), wd & 255);
        rv = 0;
        if (hit) begin
            if (a == 0) rv = m_gcr;
            else if (a == 1) rv = m_sel;
            else if (a == 2) rv = m_ptr & 255;
            else if (a == 3) rv = m_ptr >> 8;
            else if (dp) rv = int'(memfn(m_sel[5], 17'(maddr)));
            else if (wide) rv = int'(m_x[a - 8]);
            else rv = 0;
        end
        e_oe = hit && rd && !wr;
        if (hit && wr) begin
            if (a == 0) m_gcr = wd & 255;
            else if (a == 1) m_sel = wd & 255;
            else if (a == 2) m_ptr = (m_ptr & 32512) | (wd & 255);
            else if (a == 3) m_ptr = (m_ptr & 255) | ((wd & 127) << 8);
            else if (!dp && wide) m_x[a - 8] = 8'(wd);
        end
        if (hit && dp && (rd || wr)) m_ptr = (m_ptr + 1) & 32767;
        @(posedge clk); #2;
        chk(req, "io_rdata_oe", int'(io_rdata_oe), int'(e_oe));
        if (e_oe) chk(req, "io_rdata", int'(io_rdata), rv);
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    initial begin
        bit [31:0] lfsr;
        m_gcr = 0; m_sel = 0; m_ptr = 0;
        for (int i = 0; i < 32; i++) m_x[i] = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "io_rdata_oe in reset", int'(io_rdata_oe), 0);
        @(negedge clk); rst_n = 1'b1;
        // R2: disabled port ignores everything
        step(0, 1, 0, 8'h55, "R2");
        step(0, 1, 2, 8'h12, "R2");
        step(1, 0, 4, 0, "R2");
        step(0, 1, 5, 8'h99, "R2");
        cfg_index = 6'd1;
        // R1: reset values read back
        for (int a = 0; a < 4; a++) step(1, 0, a, 0, "R1");
        // R4: register access
        step(0, 1, 0, 8'hA7, "R4");
        step(1, 0, 0, 0, "R4");
        step(0, 1, 2, 8'h34, "R4");
        step(0, 1, 3, 8'hF2, "R4");
        step(1, 0, 2, 0, "R4");
        step(1, 0, 3, 0, "R4");
        // R3/R9: narrow window edges and reserved bytes
        step(0, 1, 9, 8'h66, "R9");
        step(1, 0, 9, 0, "R9");
        step(1, 0, 15, 0, "R9");
        step(1, 0, 16, 0, "R3");
        step(0, 1, 20, 8'h77, "R3");
        // R5/R6/R7: data ports, all aliases, SRAM then flash, all banks
        for (int b = 0; b < 8; b++) begin
            step(0, 1, 1, (b << 3), "R5");
            for (int k = 0; k < 4; k++) step(1, 0, 4 + k, 0, "R5");
            for (int k = 0; k < 4; k++) step(0, 1, 4 + k, 8'hC0 + k, "R6");
            step(1, 1, 6, 8'h3C, "R10");
            step(1, 0, 2, 0, "R7");
        end
        // R8: wrap at top of pointer range with bank 3, flash
        step(0, 1, 1, 8'h38, "R8");
        step(0, 1, 2, 8'hFE, "R8");
        step(0, 1, 3, 8'h7F, "R8");
        for (int k = 0; k < 4; k++) step(1, 0, 4 + k, 0, "R8");
        step(1, 0, 3, 0, "R8");
        // R9/R3: wide window
        step(0, 1, 1, 8'h04, "R3");
        for (int a = 8; a < 40; a++) step(0, 1, a, a * 7 + 3, "R9");
        for (int a = 8; a < 40; a++) step(1, 0, a, 0, "R9");
        step(1, 0, 39, 0, "R3");
        step(1, 0, 40, 0, "R3");
        step(0, 1, 45, 8'h11, "R3");
        // back to narrow: extended bytes hidden
        step(0, 1, 1, 8'h00, "R9");
        step(1, 0, 12, 0, "R9");
        step(1, 0, 20, 0, "R3");
        // mixed pseudo-random traffic
        lfsr = 32'hACE1_2357;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cfg_index = (lfsr[12:8] == 5'd0) ? 6'd0 : 6'd3;
            step(lfsr[0], lfsr[1] & ~lfsr[2], int'(lfsr[7:3]) + (lfsr[13] ? 16 : 0),
                 int'(lfsr[23:16]), "R10");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule